// File: doc/BRIEF.md
# Packed Instruction-Table Sequence Expander

This block sits between instruction fetch and decode in a 32-bit RISC pipeline. Most fetched words go straight through to the decoder. A packed word is different: it carries a fixed tag in its top bits and several 5-bit indices below the tag. The block replaces a packed word with the full 32-bit instructions stored at those indices in a 32-entry table. It sends them to the decoder one per handshake, starting with the most significant slot. Fetch is held off until the last expanded instruction has been taken.

The table is loaded through a small write port before the program runs. After that it acts as read-only: a write that arrives while a packed word is still being expanded is dropped and raises a one-cycle error pulse. Instruction memory therefore holds only table indices and never the instructions the table maps them to. A synchronous flush input drops any output in flight and any slots still pending.

Top module: `xp_expander`

## Requirements
- R1: A fetched word whose top 7 bits differ from the tag is accepted and appears unchanged on `out_word`, with `out_valid` high, in the cycle after acceptance.
- R2: A word is packed when its bits [31:25] equal the tag parameter (default 7'h7B). Its five index slots are bits [24:20], [19:15], [14:10], [9:5] and [4:0], in that order.
- R3: A packed word produces the table entries named by its slots, in slot order, one entry per output handshake. It produces at most five entries.
- R4: A slot that holds index 0 ends the expansion, and no later slot is used. If the first slot holds 0, the packed word produces no output at all.
- R5: `in_ready` stays low while expanded instructions remain to be sent after the current one. The next fetched word is accepted in the same cycle as the handshake that takes the last expanded instruction.
- R6: While `out_valid` is high and `out_ready` is low, `out_word` stays unchanged and no slot is skipped.
- R7: In the cycle after `flush` is high, `out_valid` is low, every pending slot is discarded and `in_ready` is high.
- R8: A table write made while no slots are pending stores its data, and later expansions that name that index emit the new value.
- R9: A table write made while slots are pending leaves the table unchanged. `tbl_err` is high for exactly the one cycle that follows it.
- R10: After reset, `out_valid` and `tbl_err` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Drops the output in flight and any pending slots |
| in_valid | input | 1 | A fetched word is offered |
| in_ready | output | 1 | The block accepts the fetched word |
| in_word | input | 32 | Fetched instruction word |
| out_valid | output | 1 | An instruction is offered to the decoder |
| out_ready | input | 1 | The decoder takes the instruction |
| out_word | output | 32 | Instruction sent to the decoder |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | 5 | Table write index |
| tbl_data | input | 32 | Table write data |
| tbl_err | output | 1 | Pulse: a table write was rejected |

## Verification
The bench builds the block with its default parameters: a 7-bit tag of 7'h7B, 5-bit indices, a 32-entry table and five slots. These values make every slot position reachable. They also cover a burst cut short by a zero index at slot one and slot three, and the full five-slot burst that exercises the counter at its limit. Ordinary words include a tag one value away from the real one, so the tag compare is tested at its edge. Backpressure, flush and the rejected write are each applied partway through a burst, so that pending slots are present when they happen.

// File: rtl/xp_pkg.sv
package xp_pkg;
  // Action the sequencer takes in one cycle
  typedef enum logic [2:0] {
    XP_HOLD,    // nothing changes
    XP_PASS,    // ordinary word moves to the output
    XP_LOAD,    // packed word starts a burst
    XP_EMPTY,   // packed word whose first slot is zero
    XP_STEP,    // next slot replaces the taken output
    XP_RETIRE,  // last output taken, nothing new
    XP_FLUSH    // abort
  } xp_op_e;
endpackage

// File: rtl/xp_table.sv
module xp_table #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  assign rd_data = mem[rd_idx];
endmodule

// File: rtl/xp_seq.sv
module xp_seq
  import xp_pkg::*;
#(
  parameter int          XLEN    = 32,
  parameter int          TAG_W   = 7,
  parameter int          IDX_W   = 5,
  parameter int          SLOTS   = 5,
  parameter logic [TAG_W-1:0] TAG_VAL = 7'h7B
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [XLEN-1:0]  in_word,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [XLEN-1:0]  out_word,
  output logic [IDX_W-1:0] rd_idx,
  input  logic [XLEN-1:0]  rd_data,
  output logic             busy
);
  localparam int FIELD_W = IDX_W * SLOTS;
  localparam int REM_W   = IDX_W * (SLOTS - 1);
  localparam int CNT_W   = $clog2(SLOTS);

  function automatic logic is_packed(input logic [XLEN-1:0] w);
    return w[XLEN-1 -: TAG_W] == TAG_VAL;
  endfunction

  function automatic logic [IDX_W-1:0] top_idx(input logic [REM_W-1:0] r);
    return r[REM_W-1 -: IDX_W];
  endfunction

  logic [REM_W-1:0] rem;
  logic [CNT_W-1:0] cnt;
  logic             pend;

  // named events for the assertions
  logic ev_take, ev_give, ev_packed;
  logic [IDX_W-1:0] first_idx;
  logic [REM_W-1:0] rem_ld, rem_sh;
  logic more_ld, more_st;
  xp_op_e op;

  assign in_ready  = !pend && !flush && (!out_valid || out_ready);
  assign ev_take   = in_valid && in_ready;
  assign ev_give   = out_valid && out_ready;
  assign ev_packed = is_packed(in_word);
  assign first_idx = in_word[FIELD_W-1 -: IDX_W];
  assign rem_ld    = in_word[REM_W-1:0];
  assign rem_sh    = rem << IDX_W;
  assign more_ld   = top_idx(rem_ld) != '0;
  assign more_st   = (cnt != CNT_W'(1)) && (top_idx(rem_sh) != '0);
  assign rd_idx    = pend ? top_idx(rem) : first_idx;
  assign busy      = pend;

  always_comb begin
    op = XP_HOLD;
    if (flush)                    op = XP_FLUSH;
    else if (ev_take && !ev_packed) op = XP_PASS;
    else if (ev_take && first_idx == '0) op = XP_EMPTY;
    else if (ev_take)             op = XP_LOAD;
    else if (ev_give && pend)     op = XP_STEP;
    else if (ev_give)             op = XP_RETIRE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      pend      <= 1'b0;
      rem       <= '0;
      cnt       <= '0;
    end else begin
      unique case (op)
        XP_FLUSH: begin
          out_valid <= 1'b0;
          pend      <= 1'b0;
          cnt       <= '0;
        end
        XP_PASS: begin
          out_valid <= 1'b1;
          out_word  <= in_word;
          pend      <= 1'b0;
        end
        XP_EMPTY: begin
          out_valid <= 1'b0;
          pend      <= 1'b0;
        end
        XP_LOAD: begin
          out_valid <= 1'b1;
          out_word  <= rd_data;
          rem       <= rem_ld;
          cnt       <= CNT_W'(SLOTS - 1);
          pend      <= more_ld;
        end
        XP_STEP: begin
          out_word  <= rd_data;
          rem       <= rem_sh;
          cnt       <= cnt - 1'b1;
          pend      <= more_st;
        end
        XP_RETIRE: out_valid <= 1'b0;
        default: ;
      endcase
    end
  end

  assert_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_take && !ev_packed) |=> (out_valid && out_word == $past(in_word)))
    else $error("R1 pass-through mismatch");

  assert_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_take && ev_packed && first_idx != '0 &&
     in_word[FIELD_W-IDX_W-1 -: IDX_W] != '0) |=> !in_ready)
    else $error("R5 fetch not stalled");

  assert_cnt_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> (cnt != '0 && cnt <= CNT_W'(SLOTS - 1)))
    else $error("R3 slot counter out of range");

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !flush) |=> (out_valid && $stable(out_word)))
    else $error("R6 output moved under backpressure");

  assert_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!out_valid && !busy))
    else $error("R7 flush did not clear");
endmodule

// File: rtl/xp_expander.sv
module xp_expander #(
  parameter int          XLEN    = 32,
  parameter int          TAG_W   = 7,
  parameter int          IDX_W   = 5,
  parameter int          SLOTS   = 5,
  parameter logic [TAG_W-1:0] TAG_VAL = 7'h7B
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [XLEN-1:0]  in_word,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [XLEN-1:0]  out_word,
  input  logic             tbl_we,
  input  logic [IDX_W-1:0] tbl_addr,
  input  logic [XLEN-1:0]  tbl_data,
  output logic             tbl_err
);
  logic             busy;
  logic             wr_ok, wr_reject;
  logic [IDX_W-1:0] rd_idx;
  logic [XLEN-1:0]  rd_data;

  assign wr_reject = tbl_we && busy;
  assign wr_ok     = tbl_we && !busy;

  xp_table #(.DATA_W(XLEN), .IDX_W(IDX_W)) u_table (
    .clk     (clk),
    .wr_en   (wr_ok),
    .wr_idx  (tbl_addr),
    .wr_data (tbl_data),
    .rd_idx  (rd_idx),
    .rd_data (rd_data)
  );

  xp_seq #(
    .XLEN(XLEN), .TAG_W(TAG_W), .IDX_W(IDX_W), .SLOTS(SLOTS), .TAG_VAL(TAG_VAL)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_word   (in_word),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_word  (out_word),
    .rd_idx    (rd_idx),
    .rd_data   (rd_data),
    .busy      (busy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) tbl_err <= 1'b0;
    else        tbl_err <= wr_reject;
  end

  assert_reject_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reject |=> tbl_err)
    else $error("R9 rejected write not flagged");

  assert_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_reject |=> !tbl_err)
    else $error("R9 spurious error pulse");
endmodule

// File: tb/xp_expander_tb.sv
`timescale 1ns/1ps
module xp_expander_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_word = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_word;
  logic        tbl_we = 1'b0;
  logic [4:0]  tbl_addr = '0;
  logic [31:0] tbl_data = '0;
  logic        tbl_err;

  int nchk = 0;
  int nfail = 0;
  logic [31:0] got [64];
  int n_got = 0;

  always #2.5 clk = ~clk;

  xp_expander u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_data(tbl_data), .tbl_err(tbl_err)
  );

  // decoder model: records every taken instruction, sampled mid-cycle
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (n_got < 64) got[n_got] = out_word;
      n_got = n_got + 1;
    end
  end

  function automatic logic [31:0] ent(input int i);
    return 32'h0C00_0000 ^ (i * 32'h0001_0203) ^ (i << 24);
  endfunction

  function automatic logic [31:0] pk(input logic [4:0] a, b, c, d, e);
    return {7'h7B, a, b, c, d, e};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic send(input logic [31:0] w);
    int waited = 0;
    in_valid = 1'b1;
    in_word  = w;
    @(negedge clk);
    while (!in_ready && waited < 200) begin
      @(negedge clk);
      waited++;
    end
    if (waited >= 200) chk("R5 send timeout", 32'd0, 32'd1);
    tick();
    in_valid = 1'b0;
  endtask

  task automatic wrt(input logic [4:0] a, input logic [31:0] d);
    tbl_we = 1'b1; tbl_addr = a; tbl_data = d;
    tick();
    tbl_we = 1'b0;
  endtask

  task automatic drain(input int k);
    repeat (k) tick();
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R10 out_valid", {31'd0, out_valid}, 32'd0);
    chk("R10 in_ready", {31'd0, in_ready}, 32'd1);
    chk("R10 tbl_err", {31'd0, tbl_err}, 32'd0);
    tick();
  endtask

  task automatic t_load();
    for (int i = 1; i < 32; i++) wrt(5'(i), ent(i));
  endtask

  task automatic t_pass();
    int base = n_got;
    out_ready = 1'b1;
    send(32'h1234_5678);
    send({7'h7A, 25'h1ABCDEF});
    drain(3);
    chk("R1 count", n_got - base, 2);
    chk("R1 first word", got[base], 32'h1234_5678);
    chk("R2 near-tag word passes", got[base+1], {7'h7A, 25'h1ABCDEF});
  endtask

  task automatic t_full();
    int base = n_got;
    out_ready = 1'b1;
    send(pk(1, 2, 3, 4, 5));
    @(negedge clk);
    chk("R5 fetch held during burst", {31'd0, in_ready}, 32'd0);
    send(32'h0000_0013);
    drain(3);
    chk("R3 count five slots plus next word", n_got - base, 6);
    for (int k = 0; k < 5; k++) chk("R3 slot order", got[base+k], ent(k + 1));
    chk("R5 next word follows burst", got[base+5], 32'h0000_0013);
  endtask

  task automatic t_early();
    int base = n_got;
    out_ready = 1'b1;
    send(pk(7, 9, 0, 4, 5));
    drain(4);
    chk("R4 stops at zero slot", n_got - base, 2);
    chk("R4 slot one", got[base], ent(7));
    chk("R4 slot two", got[base+1], ent(9));
    base = n_got;
    send(pk(0, 3, 3, 3, 3));
    drain(3);
    chk("R4 zero first slot gives nothing", n_got - base, 0);
    send(32'hAAAA_5555);
    drain(3);
    chk("R4 following word", got[base], 32'hAAAA_5555);
  endtask

  task automatic t_backpressure();
    int base = n_got;
    out_ready = 1'b0;
    send(pk(10, 11, 12, 0, 0));
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R6 valid held", {31'd0, out_valid}, 32'd1);
      chk("R6 word held", out_word, ent(10));
    end
    tick();
    wrt(5'd10, 32'hDEAD_BEEF);
    @(negedge clk);
    chk("R9 error pulse", {31'd0, tbl_err}, 32'd1);
    tick();
    @(negedge clk);
    chk("R9 pulse one cycle", {31'd0, tbl_err}, 32'd0);
    tick();
    out_ready = 1'b1;
    drain(5);
    chk("R6 no slot lost", n_got - base, 3);
    chk("R6 slot 1", got[base], ent(10));
    chk("R6 slot 2", got[base+1], ent(11));
    chk("R6 slot 3", got[base+2], ent(12));
    base = n_got;
    send(pk(10, 0, 0, 0, 0));
    drain(3);
    chk("R9 table unchanged", got[base], ent(10));
  endtask

  task automatic t_flush();
    int base;
    out_ready = 1'b0;
    send(pk(1, 2, 3, 4, 5));
    tick();
    flush = 1'b1;
    tick();
    flush = 1'b0;
    @(negedge clk);
    chk("R7 out_valid cleared", {31'd0, out_valid}, 32'd0);
    chk("R7 in_ready restored", {31'd0, in_ready}, 32'd1);
    tick();
    out_ready = 1'b1;
    base = n_got;
    send(32'h0BAD_F00D);
    drain(4);
    chk("R7 nothing left from burst", n_got - base, 1);
    chk("R7 next word", got[base], 32'h0BAD_F00D);
  endtask

  task automatic t_write();
    int base = n_got;
    wrt(5'd20, 32'hCAFE_F00D);
    @(negedge clk);
    chk("R8 no error when idle", {31'd0, tbl_err}, 32'd0);
    tick();
    send(pk(20, 21, 0, 0, 0));
    drain(4);
    chk("R8 new value used", got[base], 32'hCAFE_F00D);
    chk("R8 neighbour intact", got[base+1], ent(21));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_load();
    t_pass();
    t_full();
    t_early();
    t_backpressure();
    t_flush();
    t_write();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule